// File: doc/BRIEF.md
# Serial Management Frame Slave

This block is the device side of a two-wire management bus. The bus clock is used directly as the block clock. The data line is sampled on each rising edge. A frame is decoded bit by bit: an optional run of idle ones, a two-bit start mark, a two-bit command, the device address, the register index, a two-bit bus handover and sixteen data bits. Read and write requests go out to an external 32-entry register store. On a read, the returned word is shifted back onto the line through an output-enable pair, so the pad can act as an open tri-state.

Two control bits are held inside the block rather than in the external store:

- **Header-skip enable.** When set, the block accepts frames that have no run of leading ones.
- **Unlock bit.** A write to the header-skip enable only takes effect while the unlock bit is set. The unlock bit is used up by the next write that is not aimed at its own register.

On reads of the registers that hold these two bits, the block substitutes its own values into the word returned from the store.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While header-skip is off, a frame is accepted only if at least 32 consecutive ones were sampled before its start mark. After 31 ones, or with no ones at all, the block drives nothing and raises no strobe.
- R2: The start mark is 0 then 1. The command follows, first-sent bit being the high bit: 10 is a read and 01 is a write. `rf_rd_stb` and `rf_wr_stb` are never high together.
- R3: Commands 00 and 11 get no response: `mdio_oe` stays low for the whole frame, and no register changes.
- R4: The 5-bit device address (high bit first) must equal `phy_addr`. On a mismatch, a read drives nothing and a write changes no register.
- R5: Read timing after the 5-bit register index:
  - During the first handover bit the line is released.
  - During the second handover bit 0 is driven.
  - Then the 16 bits of the selected register are driven, high bit first. Each bit is driven from just after one rising edge until the next.
  - The line is released in the following bit period.
- R6: A write needs handover bits 1 then 0. The 16 data bits (high bit first) reach `rf_wdata`/`rf_addr` with a one-cycle `rf_wr_stb` pulse after the last bit. A write with any other handover pattern changes nothing.
- R7: The header-skip enable (register 1, bit 6) resets to 0, shows on `sup_en`, and reads back in bit 6 of register 1. A write to register 1 changes it only while the unlock bit is set; otherwise it is left as it was.
- R8: The unlock bit (register 16, bit 15) is loaded by any write to register 16 and reads back in bit 15 of register 16. It is cleared by the next write to any other register. Reads do not clear it.
- R9: While header-skip is on, a frame whose start mark follows a zero bit with no run of ones is accepted.
- R10: Reset leaves `mdio_oe` low, `sup_en` low and `rf_wr_stb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management bus clock; line sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdio_i | input | 1 | Sampled level of the data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| phy_addr | input | 5 | Device address this block answers to |
| rf_rd_stb | output | 1 | One-cycle read request to the register store |
| rf_wr_stb | output | 1 | One-cycle write request to the register store |
| rf_addr | output | 5 | Register index for the current request |
| rf_wdata | output | 16 | Write data for the register store |
| rf_rdata | input | 16 | Read data from the register store, valid while `rf_rd_stb` is high |
| sup_en | output | 1 | Current header-skip enable |

## Verification
The bench targets the boundary between 31 and 32 leading ones. A counter that is off by one would either answer a short header or need 33 ones.

It also covers:
- Frames with illegal commands, a foreign address or a broken handover. A parser that fails to abort would drive the line or corrupt a register.
- The handover bit periods of a read. A design driving one bit early would collide with the station, and one driving a bit late would shift every data bit.
- The unlock rule. The bench tries to set header-skip without unlocking, after the unlock has been spent on another register, and properly unlocked. A design that ignored the gate, or never spent the unlock, would accept frames without a header at the wrong time.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  localparam int DW   = 16;
  localparam int AW   = 5;
  localparam int CNTW = $clog2(DW);
  localparam int DBW  = $clog2(DW);

  localparam logic [1:0] CMD_RD = 2'b10;
  localparam logic [1:0] CMD_WR = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MARK,
    S_CMD,
    S_DEV,
    S_IDX,
    S_TURN,
    S_DATA
  } frm_st_e;

  function automatic logic cmd_ok(input logic [1:0] cmd);
    return (cmd == CMD_RD) || (cmd == CMD_WR);
  endfunction

  function automatic logic [DW-1:0] put_bit(input logic [DW-1:0] w,
                                             input int unsigned pos,
                                             input logic v);
    logic [DW-1:0] r;
    r = w;
    r[pos[DBW-1:0]] = v;
    return r;
  endfunction

  function automatic logic turn_bad(input logic is_rd, input logic second,
                                    input logic b);
    if (is_rd) return 1'b0;
    return second ? b : ~b;
  endfunction

endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic clr_i,
  output logic pre_ok_o,
  output logic resync_o
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(PRE_LEN);
  localparam logic [CW-1:0] LAST = CW'(PRE_LEN - 1);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ones_q <= '0;
    else if (clr_i)          ones_q <= '0;
    else if (!bit_i)         ones_q <= '0;
    else if (ones_q != FULL) ones_q <= ones_q + CW'(1);
  end

  assign pre_ok_o = (ones_q == FULL);
  assign resync_o = bit_i && (ones_q == LAST);
endmodule

// File: rtl/mdio_frm_fsm.sv
module mdio_frm_fsm
  import mdio_slv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_i,
  input  logic          gate_ok_i,
  input  logic          resync_i,
  input  logic [AW-1:0] phy_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          clr_o,
  output logic          rd_stb_o,
  output logic          wr_done_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          drv_oe_o,
  output logic          drv_bit_o,
  output logic          op_bad_o,
  output logic          addr_miss_o,
  output logic          turn_bad_o
);
  localparam logic [CNTW-1:0] AW_LAST = CNTW'(AW - 1);
  localparam logic [CNTW-1:0] DW_LAST = CNTW'(DW - 1);

  frm_st_e          st_q;
  logic [CNTW-1:0]  cnt_q;
  logic [DW-2:0]    sh_q;
  logic             is_rd_q;
  logic [AW-1:0]    reg_q;
  logic [DW-1:0]    out_q;
  logic [DW-1:0]    wdata_q;
  logic             wr_done_q;

  logic [1:0]       cmd_now;
  logic [AW-1:0]    field_now;
  logic [DW-1:0]    word_now;
  logic             mark_bad;
  logic             data_last;
  logic             in_frame;
  logic             start_ok;

  assign cmd_now   = {sh_q[0], bit_i};
  assign field_now = {sh_q[AW-2:0], bit_i};
  assign word_now  = {sh_q, bit_i};
  assign in_frame  = (st_q != S_IDLE);
  assign start_ok  = (st_q == S_IDLE) && !bit_i && gate_ok_i;

  assign op_bad_o    = (st_q == S_CMD) && (cnt_q == CNTW'(1)) && !cmd_ok(cmd_now);
  assign addr_miss_o = (st_q == S_DEV) && (cnt_q == AW_LAST) && (field_now != phy_addr_i);
  assign turn_bad_o  = (st_q == S_TURN) && turn_bad(is_rd_q, cnt_q[0], bit_i);
  assign mark_bad    = (st_q == S_MARK) && !bit_i;
  assign data_last   = (st_q == S_DATA) && (cnt_q == DW_LAST);

  assign clr_o = in_frame && !resync_i &&
                 (op_bad_o || addr_miss_o || turn_bad_o || mark_bad || data_last);

  assign rd_stb_o   = (st_q == S_TURN) && (cnt_q == '0) && is_rd_q;
  assign drv_oe_o   = is_rd_q && (((st_q == S_TURN) && cnt_q[0]) || (st_q == S_DATA));
  assign drv_bit_o  = (st_q == S_DATA) ? out_q[DW-1] : 1'b0;
  assign reg_addr_o = reg_q;
  assign wr_data_o  = wdata_q;
  assign wr_done_o  = wr_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      is_rd_q   <= 1'b0;
      reg_q     <= '0;
      out_q     <= '0;
      wdata_q   <= '0;
      wr_done_q <= 1'b0;
    end else begin
      wr_done_q <= 1'b0;
      if (in_frame && resync_i) begin
        st_q  <= S_IDLE;
        cnt_q <= '0;
      end else begin
        case (st_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (start_ok) st_q <= S_MARK;
          end
          S_MARK: begin
            cnt_q <= '0;
            st_q  <= bit_i ? S_CMD : S_IDLE;
          end
          S_CMD: begin
            sh_q <= {sh_q[DW-3:0], bit_i};
            if (cnt_q == CNTW'(1)) begin
              cnt_q   <= '0;
              is_rd_q <= (cmd_now == CMD_RD);
              st_q    <= op_bad_o ? S_IDLE : S_DEV;
            end else begin
              cnt_q <= cnt_q + CNTW'(1);
            end
          end
          S_DEV: begin
            sh_q <= {sh_q[DW-3:0], bit_i};
            if (cnt_q == AW_LAST) begin
              cnt_q <= '0;
              st_q  <= addr_miss_o ? S_IDLE : S_IDX;
            end else begin
              cnt_q <= cnt_q + CNTW'(1);
            end
          end
          S_IDX: begin
            sh_q <= {sh_q[DW-3:0], bit_i};
            if (cnt_q == AW_LAST) begin
              cnt_q <= '0;
              reg_q <= field_now;
              st_q  <= S_TURN;
            end else begin
              cnt_q <= cnt_q + CNTW'(1);
            end
          end
          S_TURN: begin
            if (turn_bad_o) begin
              st_q  <= S_IDLE;
              cnt_q <= '0;
            end else if (cnt_q == '0) begin
              cnt_q <= CNTW'(1);
              if (is_rd_q) out_q <= rd_data_i;
            end else begin
              cnt_q <= '0;
              st_q  <= S_DATA;
            end
          end
          S_DATA: begin
            if (is_rd_q) out_q <= {out_q[DW-2:0], 1'b0};
            else         sh_q  <= {sh_q[DW-3:0], bit_i};
            if (cnt_q == DW_LAST) begin
              cnt_q <= '0;
              st_q  <= S_IDLE;
              if (!is_rd_q) begin
                wdata_q   <= word_now;
                wr_done_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + CNTW'(1);
            end
          end
          default: begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_ovr_ctl.sv
module mdio_ovr_ctl
  import mdio_slv_pkg::*;
#(
  parameter int unsigned SUP_REG = 1,
  parameter int unsigned SUP_BIT = 6,
  parameter int unsigned OVR_REG = 16,
  parameter int unsigned OVR_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sup_bit_i,
  input  logic          ovr_bit_i,
  input  logic [DW-1:0] rf_rdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          sup_en_o,
  output logic          ovr_o
);
  localparam logic [AW-1:0] SUP_A = AW'(SUP_REG);
  localparam logic [AW-1:0] OVR_A = AW'(OVR_REG);

  logic sup_q;
  logic ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == OVR_A) begin
        ovr_q <= ovr_bit_i;
      end else if (ovr_q) begin
        ovr_q <= 1'b0;
        if (addr_i == SUP_A) sup_q <= sup_bit_i;
      end
    end
  end

  always_comb begin
    rd_data_o = rf_rdata_i;
    if (addr_i == SUP_A) rd_data_o = put_bit(rf_rdata_i, SUP_BIT, sup_q);
    if (addr_i == OVR_A) rd_data_o = put_bit(rf_rdata_i, OVR_BIT, ovr_q);
  end

  assign sup_en_o = sup_q;
  assign ovr_o    = ovr_q;
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int          PRE_LEN = 32,
  parameter int unsigned SUP_REG = 1,
  parameter int unsigned SUP_BIT = 6,
  parameter int unsigned OVR_REG = 16,
  parameter int unsigned OVR_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic [AW-1:0] phy_addr,
  output logic          rf_rd_stb,
  output logic          rf_wr_stb,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata,
  output logic          sup_en
);
  logic          pre_ok;
  logic          resync;
  logic          clr;
  logic          wr_done;
  logic          ovr_q;
  logic          op_bad;
  logic          addr_miss;
  logic          turn_bad;
  logic [DW-1:0] rd_merged;
  logic [DW-1:0] wdata;
  logic [AW-1:0] reg_addr;

  mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_i    (mdio_i),
    .clr_i    (clr),
    .pre_ok_o (pre_ok),
    .resync_o (resync)
  );

  mdio_frm_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_i       (mdio_i),
    .gate_ok_i   (pre_ok || sup_en),
    .resync_i    (resync),
    .phy_addr_i  (phy_addr),
    .rd_data_i   (rd_merged),
    .clr_o       (clr),
    .rd_stb_o    (rf_rd_stb),
    .wr_done_o   (wr_done),
    .reg_addr_o  (reg_addr),
    .wr_data_o   (wdata),
    .drv_oe_o    (mdio_oe),
    .drv_bit_o   (mdio_o),
    .op_bad_o    (op_bad),
    .addr_miss_o (addr_miss),
    .turn_bad_o  (turn_bad)
  );

  mdio_ovr_ctl #(
    .SUP_REG (SUP_REG),
    .SUP_BIT (SUP_BIT),
    .OVR_REG (OVR_REG),
    .OVR_BIT (OVR_BIT)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_done),
    .addr_i     (reg_addr),
    .sup_bit_i  (wdata[SUP_BIT]),
    .ovr_bit_i  (wdata[OVR_BIT]),
    .rf_rdata_i (rf_rdata),
    .rd_data_o  (rd_merged),
    .sup_en_o   (sup_en),
    .ovr_o      (ovr_q)
  );

  assign rf_wr_stb = wr_done;
  assign rf_addr   = reg_addr;
  assign rf_wdata  = wdata;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rf_rd_stb,
  input logic rf_wr_stb,
  input logic sup_en,
  input logic ovr_q,
  input logic op_bad,
  input logic addr_miss,
  input logic turn_bad
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_rd_stb && rf_wr_stb)); // R2

  AST_BAD_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_bad |=> !mdio_oe && !rf_rd_stb); // R3

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !mdio_oe && !rf_rd_stb); // R4

  AST_TURN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R5

  AST_OE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(rf_rd_stb)); // R5

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_stb |=> !rf_wr_stb); // R6

  AST_TURN_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    turn_bad |=> !rf_wr_stb); // R6

  AST_SUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en != $past(sup_en)) |-> $past(ovr_q)); // R7
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (.*);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_oe = 1'b0;
  logic        st_bit = 1'b1;
  logic        mdio_o, mdio_oe;
  logic [4:0]  phy_addr = 5'h0B;
  logic        rf_rd_stb, rf_wr_stb, sup_en;
  logic [4:0]  rf_addr;
  logic [15:0] rf_wdata, rf_rdata;
  logic [15:0] rf_mem [32];
  logic        line;
  logic        saw_oe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (st_oe ? st_bit : 1'b1);

  mdio_mgmt_slave dut (
    .clk(clk), .rst_n(rst_n), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .phy_addr(phy_addr), .rf_rd_stb(rf_rd_stb), .rf_wr_stb(rf_wr_stb),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .sup_en(sup_en)
  );

  assign rf_rdata = rf_mem[rf_addr];
  always @(posedge clk) if (rf_wr_stb) rf_mem[rf_addr] <= rf_wdata;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read, 2 station-only frame expecting silence
    logic [1:0]  cmd;
    logic [4:0]  dev;
    logic [4:0]  idx;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'b01, 5'h0B, 5'd5,  16'hA5C3},
    '{2'd1, 2'b10, 5'h0B, 5'd5,  16'hA5C3},
    '{2'd0, 2'b01, 5'h0B, 5'd31, 16'hFFFF},
    '{2'd1, 2'b10, 5'h0B, 5'd31, 16'hFFFF},
    '{2'd0, 2'b01, 5'h0B, 5'd0,  16'h0000},
    '{2'd1, 2'b10, 5'h0B, 5'd0,  16'h0000},
    '{2'd2, 2'b00, 5'h0B, 5'd5,  16'h1234},
    '{2'd2, 2'b11, 5'h0B, 5'd5,  16'h1234},
    '{2'd1, 2'b10, 5'h0B, 5'd5,  16'hA5C3},
    '{2'd0, 2'b01, 5'h0A, 5'd5,  16'h0F0F},
    '{2'd2, 2'b10, 5'h0A, 5'd5,  16'h0000},
    '{2'd1, 2'b10, 5'h0B, 5'd5,  16'hA5C3},
    '{2'd1, 2'b10, 5'h0B, 5'd9,  16'h4999}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (mdio_oe) saw_oe = 1'b1;
    st_oe = 1'b1;
    st_bit = b;
    @(posedge clk);
  endtask

  task automatic rel_bit(output logic b, output logic oe);
    @(negedge clk);
    st_oe = 1'b0;
    b = line;
    oe = mdio_oe;
    @(posedge clk);
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] cmd,
                          input logic [4:0] dev, input logic [4:0] idx);
    saw_oe = 1'b0;
    repeat (pre) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(cmd[i]);
    for (int i = 4; i >= 0; i--) send_bit(dev[i]);
    for (int i = 4; i >= 0; i--) send_bit(idx[i]);
  endtask

  // Frame fully driven by the station; returns whether the slave ever drove
  task automatic do_station(input int pre, input logic [1:0] cmd, input logic [4:0] dev,
                            input logic [4:0] idx, input logic [1:0] turn,
                            input logic [15:0] d, output logic drove);
    send_hdr(pre, cmd, dev, idx);
    send_bit(turn[1]);
    send_bit(turn[0]);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    send_bit(1'b1);
    send_bit(1'b1);
    drove = saw_oe;
  endtask

  task automatic do_write(input int pre, input logic [4:0] dev, input logic [4:0] idx,
                          input logic [15:0] d);
    logic drove;
    do_station(pre, 2'b01, dev, idx, 2'b10, d, drove);
  endtask

  task automatic do_read(input int pre, input logic [4:0] idx,
                         output logic [15:0] d, output logic timing_ok);
    logic b, oe;
    send_hdr(pre, 2'b10, phy_addr, idx);
    timing_ok = !saw_oe;
    rel_bit(b, oe);
    if (oe) timing_ok = 1'b0;
    rel_bit(b, oe);
    if (!oe || b) timing_ok = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      rel_bit(b, oe);
      if (!oe) timing_ok = 1'b0;
      d[i] = b;
    end
    rel_bit(b, oe);
    if (oe) timing_ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [15:0] rd;
    logic        ok;
    logic        drove;
    for (int i = 0; i < 32; i++) rf_mem[i] = 16'(16'h4000 + i * 16'h0111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 oe in reset", {31'd0, mdio_oe}, 32'd0);
    chk("R10 sup_en in reset", {31'd0, sup_en}, 32'd0);
    chk("R10 wr strobe in reset", {31'd0, rf_wr_stb}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Table of frames (R2 R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].kind)
        2'd0: do_write(32, VECS[v].dev, VECS[v].idx, VECS[v].data);
        2'd1: begin
          do_read(32, VECS[v].idx, rd, ok);
          chk("R5 read handover/drive timing", {31'd0, ok}, 32'd1);
          chk("R2 R6 read data", {16'd0, rd}, {16'd0, VECS[v].data});
        end
        default: begin
          do_station(32, VECS[v].cmd, VECS[v].dev, VECS[v].idx, 2'b10, VECS[v].data, drove);
          chk((VECS[v].cmd == 2'b10) ? "R4 foreign address silent" : "R3 bad command silent",
              {31'd0, drove}, 32'd0);
        end
      endcase
    end

    // R1: 31 ones, and no ones at all, are not enough; 32 are
    send_bit(1'b0);
    do_station(31, 2'b10, 5'h0B, 5'd5, 2'b11, 16'hFFFF, drove);
    chk("R1 31-one header ignored", {31'd0, drove}, 32'd0);
    send_bit(1'b0);
    send_bit(1'b0);
    do_station(0, 2'b10, 5'h0B, 5'd5, 2'b11, 16'hFFFF, drove);
    chk("R1 headerless frame ignored", {31'd0, drove}, 32'd0);
    send_bit(1'b0);
    do_read(32, 5'd5, rd, ok);
    chk("R1 exact 32-one header", {15'd0, ok, rd}, {15'd0, 1'b1, 16'hA5C3});

    // R6: bad handover patterns leave the register alone
    do_station(32, 2'b01, 5'h0B, 5'd5, 2'b00, 16'h1111, drove);
    do_station(32, 2'b01, 5'h0B, 5'd5, 2'b11, 16'h2222, drove);
    do_read(32, 5'd5, rd, ok);
    chk("R6 bad handover no write", {16'd0, rd}, {16'd0, 16'hA5C3});

    // R7: locked write has no effect
    do_write(32, 5'h0B, 5'd1, 16'h0040);
    chk("R7 locked write ignored", {31'd0, sup_en}, 32'd0);
    do_read(32, 5'd1, rd, ok);
    chk("R7 reg1 bit6 reads 0", {31'd0, rd[6]}, 32'd0);

    // R8: unlock is visible, survives a read, and is spent on another register
    do_write(32, 5'h0B, 5'd16, 16'h8000);
    do_read(32, 5'd16, rd, ok);
    chk("R8 unlock bit reads 1", {31'd0, rd[15]}, 32'd1);
    do_write(32, 5'h0B, 5'd5, 16'h5A5A);
    do_read(32, 5'd16, rd, ok);
    chk("R8 unlock spent by other write", {31'd0, rd[15]}, 32'd0);
    do_write(32, 5'h0B, 5'd1, 16'h0040);
    chk("R7 write after spent unlock ignored", {31'd0, sup_en}, 32'd0);

    // R7: proper unlock enables header-skip
    do_write(32, 5'h0B, 5'd16, 16'h8000);
    do_write(32, 5'h0B, 5'd1, 16'h0040);
    chk("R7 unlocked write sets sup_en", {31'd0, sup_en}, 32'd1);
    do_read(32, 5'd1, rd, ok);
    chk("R7 reg1 bit6 reads 1", {31'd0, rd[6]}, 32'd1);
    do_read(32, 5'd16, rd, ok);
    chk("R8 unlock cleared after use", {31'd0, rd[15]}, 32'd0);

    // R9: frame without header accepted now
    send_bit(1'b0);
    send_bit(1'b0);
    do_read(0, 5'd5, rd, ok);
    chk("R9 headerless read accepted", {15'd0, ok, rd}, {15'd0, 1'b1, 16'h5A5A});

    // R7: clearing without unlock is ignored too
    do_write(32, 5'h0B, 5'd1, 16'h0000);
    chk("R7 locked clear ignored", {31'd0, sup_en}, 32'd1);

    // R10: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears sup_en", {31'd0, sup_en}, 32'd0);
    chk("R10 reset oe low", {31'd0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    done = 1'b1;
    report();
  end
endmodule